// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block merges a bank of level-sensitive interrupt request lines into a single interrupt line toward a processor. Software owns a per-source enable mask and a table of one 32-bit word per source; each word is whatever value software wants to see back when that source is serviced, typically a handler index. Entries that software has not filled hold a fixed sentinel value so that a stray service can be recognised.

When the controller is enabled and idle, it picks the lowest-numbered request that is both present and unmasked. It copies that source's table word into a vector holding register and drives the processor line active. The line stays active, and the choice stays fixed, until software writes the end-of-interrupt register. Requests arriving in the meantime wait. The output polarity is programmable. Turning the controller off forces the line inactive and abandons any service in progress.

All registers sit on a simple word-aligned 32-bit register port with a single-cycle write strobe and combinational read data.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the control word reads 0, the mask reads 0, the output line is high (inactive, active-low), the vector register reads 0x12345678, and every table entry reads 0x12345678.
- R2: A write to offset 0x08 sets each mask bit where the written data has a 1. A write to 0x0C clears each mask bit where the data has a 1. Offset 0x10 reads the current mask, with bit n gating source n.
- R3: Offset 0x04 reads the input levels after two synchronising flops, whatever the mask holds. A change on an input is visible there after exactly two rising edges.
- R4: When enabled and idle, the controller services the lowest-numbered source that is both high and unmasked. The output turns active on the third rising edge after that input rises.
- R5: Offset 0x14 reads the table word of the source in service. It reads 0x12345678 when nothing is in service.
- R6: Table entry n sits at byte offset 0x80 + 4·n and can be written and read back.
- R7: Once a source is in service, the output and vector hold even if that input drops. Any write to 0x1C ends the service. The output is inactive in the cycle after that write, and a waiting source is serviced on the following edge.
- R8: Control bit 1 selects polarity: 1 makes the line active high, 0 makes it active low. The inactive level is the opposite.
- R9: With control bit 0 at 0 the line is held at its inactive level, and a service in progress is dropped (the vector reads the sentinel).
- R10: A source whose mask bit is 0 never causes service.
- R11: Inputs are level-sensitive. A source still high when end-of-interrupt is written is serviced again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Interrupt requests, active high, asynchronous |
| bus_addr | input | 8 | Byte address, word-aligned accesses only |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_irq | output | 1 | Merged interrupt line, polarity per control bit 1 |

## Verification
The hardest situation to reach is a second source becoming pending while the first is still in service, and then being granted exactly one cycle after the end-of-interrupt write. The stimulus raises two sources together, drops the winner's input during service to show that the hold does not depend on the input, and then writes end-of-interrupt. The output is sampled in the release cycle and again in the cycle after, where the vector must already name the second source. Disabling the controller in the middle of a service at active-high polarity is driven in a similar way.

// File: rtl/vic_pkg.sv
// Package: shared constants and types for the vectored interrupt controller.
// Assumes word-aligned byte addressing on an 8-bit register port.
package vic_pkg;

    // Word index (byte address / 4) of each control register
    localparam logic [5:0] WIX_CTRL = 6'h00;
    localparam logic [5:0] WIX_RAW  = 6'h01;
    localparam logic [5:0] WIX_SET  = 6'h02;
    localparam logic [5:0] WIX_CLR  = 6'h03;
    localparam logic [5:0] WIX_MASK = 6'h04;
    localparam logic [5:0] WIX_VEC  = 6'h05;
    localparam logic [5:0] WIX_EOI  = 6'h07;

    // Value held by table entries that software has not programmed
    localparam logic [31:0] VEC_SENTINEL = 32'h1234_5678;

    // Control word: bit 1 polarity, bit 0 enable
    typedef struct packed {
        logic pol;
        logic en;
    } vic_ctrl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } vic_state_t;

endpackage

// File: rtl/vic_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous levels.
// Assumes each bit is an independent level (no bus coherence needed).
module vic_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the sampled levels one stage further along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/vic_prio_pick.sv
// Module: fixed-priority picker, lowest index wins.
// Assumes WIDTH is a power of two no larger than 2**IDX_W.
module vic_prio_pick #(
    parameter int WIDTH = 32,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest set bit is the last to win
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH-1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vic_vec_table.sv
// Module: software-written vector table, one word per source, with two
// read ports (one for the register port, one for the grant logic).
// Assumes at most one write per cycle; entries reset to the sentinel.
module vic_vec_table
    import vic_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_data_b
);

    logic [DATA_W-1:0] entry_q [ENTRIES];

    generate
        for (genvar n = 0; n < ENTRIES; n++) begin : g_entry
            // Store the written word when this entry is addressed
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    entry_q[n] <= DATA_W'(VEC_SENTINEL);
                end else if (wr_en && (wr_idx == IDX_W'(n))) begin
                    entry_q[n] <= wr_data;
                end
            end
        end
    endgenerate

    assign rd_data_a = entry_q[rd_idx_a];
    assign rd_data_b = entry_q[rd_idx_b];

endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: vectored interrupt controller top. Holds control and mask,
// arbitrates synchronised requests, latches the granted vector and
// drives the merged interrupt line until end-of-interrupt.
// Assumes word-aligned register accesses; unaligned ones are ignored.
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_irq
);

    localparam int ID_W = $clog2(NUM_SRC);

    vic_ctrl_t          ctrl_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] sync_lvl;
    logic [NUM_SRC-1:0] pend_vec;
    vic_state_t         state_q;
    logic [ID_W-1:0]    cur_id_q;
    logic [DATA_W-1:0]  vec_q;
    logic               pick_found;
    logic [ID_W-1:0]    pick_idx;
    logic [DATA_W-1:0]  tbl_bus_rd;
    logic [DATA_W-1:0]  tbl_pick_rd;

    logic               aligned;
    logic               tbl_region;
    logic [5:0]         word_ix;
    logic [ID_W-1:0]    tbl_ix;
    logic               reg_wr;
    logic               eoi_wr;
    logic               busy;

    assign aligned    = (bus_addr[1:0] == 2'b00);
    assign tbl_region = bus_addr[ADDR_W-1];
    assign word_ix    = 6'(bus_addr[ADDR_W-2:2]);
    assign tbl_ix     = bus_addr[ID_W+1:2];
    assign reg_wr     = bus_wr && aligned && !tbl_region;
    assign eoi_wr     = reg_wr && (word_ix == WIX_EOI);
    assign busy       = (state_q == ST_BUSY);

    vic_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (irq_in),
        .d_out (sync_lvl)
    );

    assign pend_vec = sync_lvl & mask_q;

    vic_prio_pick #(
        .WIDTH (NUM_SRC),
        .IDX_W (ID_W)
    ) i_pick (
        .req   (pend_vec),
        .found (pick_found),
        .idx   (pick_idx)
    );

    vic_vec_table #(
        .ENTRIES (NUM_SRC),
        .DATA_W  (DATA_W),
        .IDX_W   (ID_W)
    ) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && aligned && tbl_region),
        .wr_idx    (tbl_ix),
        .wr_data   (bus_wdata),
        .rd_idx_a  (tbl_ix),
        .rd_data_a (tbl_bus_rd),
        .rd_idx_b  (pick_idx),
        .rd_data_b (tbl_pick_rd)
    );

    // Control word and mask updates from register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (reg_wr) begin
            case (word_ix)
                WIX_CTRL: ctrl_q <= vic_ctrl_t'(bus_wdata[1:0]);
                WIX_SET:  mask_q <= mask_q | bus_wdata[NUM_SRC-1:0];
                WIX_CLR:  mask_q <= mask_q & ~bus_wdata[NUM_SRC-1:0];
                default:  ;
            endcase
        end
    end

    // In-service tracking: grant when idle, hold until end-of-interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_id_q <= '0;
            vec_q    <= DATA_W'(VEC_SENTINEL);
        end else if (!ctrl_q.en) begin
            state_q  <= ST_IDLE;
        end else if (busy) begin
            if (eoi_wr) begin
                state_q <= ST_IDLE;
            end
        end else if (pick_found) begin
            state_q  <= ST_BUSY;
            cur_id_q <= pick_idx;
            vec_q    <= tbl_pick_rd;
        end
    end

    // Output line: active level only while enabled and in service
    always_comb begin
        cpu_irq = (busy && ctrl_q.en) ? ctrl_q.pol : ~ctrl_q.pol;
    end

    // Register read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (tbl_region) begin
                bus_rdata = tbl_bus_rd;
            end else begin
                case (word_ix)
                    WIX_CTRL: bus_rdata = DATA_W'(ctrl_q);
                    WIX_RAW:  bus_rdata = DATA_W'(sync_lvl);
                    WIX_MASK: bus_rdata = DATA_W'(mask_q);
                    WIX_VEC:  bus_rdata = busy ? vec_q : DATA_W'(VEC_SENTINEL);
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |=> (state_q == ST_IDLE)); // R9

    AST_EOI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eoi_wr) |=> (state_q == ST_IDLE)); // R7

    AST_HOLD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eoi_wr && ctrl_q.en) |=> (busy && $stable(cur_id_q) && $stable(vec_q))); // R7

    AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (($past(pend_vec) & (NUM_SRC'(1) << cur_id_q)) != '0)); // R10

    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (($past(pend_vec) & ((NUM_SRC'(1) << cur_id_q) - NUM_SRC'(1))) == '0)); // R4

    AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cpu_irq != ctrl_q.pol)); // R8

endmodule

// File: tb/test_irq_vector_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module test_irq_vector_ctrl;

    localparam logic [31:0] SENT = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int n_checks = 0;
    int n_errors = 0;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h10, v); chk("R1 mask", v, 32'h0);
        rd(8'h14, v); chk("R1 vector", v, SENT);
        rd(8'h80, v); chk("R1 table0", v, SENT);
        rd(8'hFC, v); chk("R1 table31", v, SENT);
        chk("R1 output", 32'(cpu_irq), 32'h1);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(8'h08, 32'h0000_00F1); rd(8'h10, v); chk("R2 set", v, 32'h0000_00F1);
        wr(8'h0C, 32'h0000_0001); rd(8'h10, v); chk("R2 clear", v, 32'h0000_00F0);
        wr(8'h08, 32'h0000_0100); rd(8'h10, v); chk("R2 set keeps", v, 32'h0000_01F0);
        wr(8'h0C, 32'hFFFF_FFFF); rd(8'h10, v); chk("R2 clear all", v, 32'h0);
    endtask

    task automatic t_table;
        logic [31:0] v;
        for (int n = 0; n < 32; n++) wr(8'(8'h80 + 4*n), 32'hA000_0000 + 32'(n));
        rd(8'h8C, v); chk("R6 entry3", v, 32'hA000_0003);
        rd(8'hFC, v); chk("R6 entry31", v, 32'hA000_001F);
    endtask

    task automatic t_raw;
        logic [31:0] v;
        @(negedge clk); irq_in = 32'h8000_0005;
        tick(1); rd(8'h04, v); chk("R3 one edge", v, 32'h0);
        tick(1); rd(8'h04, v); chk("R3 two edges", v, 32'h8000_0005);
        irq_in = '0; tick(3);
    endtask

    task automatic t_service;
        logic [31:0] v;
        wr(8'h00, 32'h1);
        wr(8'h08, 32'hFFFF_FFFF);
        @(negedge clk); irq_in = 32'h0000_0208;
        tick(2); chk("R4 not yet", 32'(cpu_irq), 32'h1);
        tick(1); chk("R4 active low", 32'(cpu_irq), 32'h0);
        rd(8'h14, v); chk("R4 R5 lowest vector", v, 32'hA000_0003);
        irq_in = 32'h0000_0200;
        tick(10); chk("R7 held", 32'(cpu_irq), 32'h0);
        rd(8'h14, v); chk("R7 vector held", v, 32'hA000_0003);
        wr(8'h1C, 32'h0);
        chk("R7 released", 32'(cpu_irq), 32'h1);
        tick(1); chk("R7 next grant", 32'(cpu_irq), 32'h0);
        rd(8'h14, v); chk("R7 vector 9", v, 32'hA000_0009);
        irq_in = '0; tick(4);
        wr(8'h1C, 32'h0);
        tick(5); chk("R7 stays idle", 32'(cpu_irq), 32'h1);
        rd(8'h14, v); chk("R5 idle sentinel", v, SENT);
    endtask

    task automatic t_level;
        logic [31:0] v;
        @(negedge clk); irq_in = 32'h0000_0020;
        tick(4); chk("R11 first", 32'(cpu_irq), 32'h0);
        wr(8'h1C, 32'h0);
        tick(1); chk("R11 again", 32'(cpu_irq), 32'h0);
        rd(8'h14, v); chk("R11 vector", v, 32'hA000_0005);
        irq_in = '0; tick(4); wr(8'h1C, 32'h0); tick(2);
    endtask

    task automatic t_masked;
        logic [31:0] v;
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h08, 32'h0000_0004);
        @(negedge clk); irq_in = 32'h0000_0080;
        tick(8); chk("R10 masked ignored", 32'(cpu_irq), 32'h1);
        rd(8'h04, v); chk("R3 raw ignores mask", v, 32'h0000_0080);
        rd(8'h14, v); chk("R10 no vector", v, SENT);
        irq_in = 32'h0000_0084;
        tick(3); chk("R10 unmasked served", 32'(cpu_irq), 32'h0);
        rd(8'h14, v); chk("R10 vector 2", v, 32'hA000_0002);
        irq_in = '0; tick(4); wr(8'h1C, 32'h0); tick(2);
    endtask

    task automatic t_pol_disable;
        logic [31:0] v;
        wr(8'h00, 32'h3);
        chk("R8 idle low", 32'(cpu_irq), 32'h0);
        wr(8'h08, 32'h0000_0010);
        @(negedge clk); irq_in = 32'h0000_0010;
        tick(3); chk("R8 active high", 32'(cpu_irq), 32'h1);
        wr(8'h00, 32'h2);
        chk("R9 off inactive", 32'(cpu_irq), 32'h0);
        tick(3); chk("R9 stays off", 32'(cpu_irq), 32'h0);
        rd(8'h14, v); chk("R9 service dropped", v, SENT);
        wr(8'h00, 32'h0);
        chk("R9 R8 off active-low idle", 32'(cpu_irq), 32'h1);
        irq_in = '0;
    endtask

    initial begin
        #(8 * 100000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_mask();
        t_table();
        t_raw();
        t_service();
        t_level();
        t_masked();
        t_pol_disable();
        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule